// File: doc/BRIEF.md
# Non-volatile memory power and sleep sequencer

This block decides, cycle by cycle, whether a host may talk to an asynchronous non-volatile memory module. It watches a power-good flag (supply above its operating minimum) and a brownout flag (supply under the write-inhibit threshold). It also takes host requests to put the memory to sleep, to wake it, or to reset it. From these it drives the memory's sleep/reset pin and an access-permitted flag. Whenever access is not permitted, it forces every chip-enable strobe and the write-enable strobe high.

Every wait is counted in clock cycles from a clock-frequency parameter:
- a startup window after the supply becomes good, and again after any brownout;
- a minimum sleep-pin pulse before sleep counts as complete;
- an initialisation wait after the sleep pin is released.

A reset request is a sleep pulse followed at once by a wake.

Top module: `mram_pwr_seq`

## Requirements
- R1: While rst_ni is low, access_ok_o, sleep_pin_o and asleep_o are 0, and all of mem_en_no and mem_we_no are 1.
- R2: After pwr_good_i is first sampled high with brownout_i low, access_ok_o rises exactly STARTUP_CYC+1 clock edges later (STARTUP_CYC = CLK_MHZ*STARTUP_US). Until then the strobe outputs are 1 whatever the host drives.
- R3: When brownout_i goes high, or pwr_good_i goes low, access_ok_o drops and the strobe outputs go to 1 in the same cycle. The next power-good event starts the full startup window of R2 again.
- R4: A sleep or reset request is accepted only in the ready state and only while bus_busy_i is low. sleep_pin_o goes to 1 one edge after acceptance, and access_ok_o goes to 0 at the same edge.
- R5: asleep_o rises exactly SLEEP_CYC edges after sleep_pin_o rises (SLEEP_CYC = ceil(SLEEP_NS*CLK_MHZ/1000), at least 1).
- R6: While sleep_pin_o is 1, the strobe outputs are 1 regardless of host_en_ni and host_we_ni.
- R7: In the asleep state, wake_req_i drops sleep_pin_o at the next edge while the strobe outputs are already 1. access_ok_o then rises exactly WAKE_CYC edges after sleep_pin_o falls (WAKE_CYC = CLK_MHZ*WAKE_US).
- R8: A reset request holds sleep_pin_o high for SLEEP_CYC cycles and then releases it with no wake request. asleep_o stays 0 throughout, and access_ok_o returns WAKE_CYC edges after the release.
- R9: While access_ok_o is 1, mem_en_no equals host_en_ni and mem_we_no equals host_we_ni.
- R10: wake_req_i outside the asleep state, and sleep_req_i outside the ready state, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply is above its operating minimum |
| brownout_i | input | 1 | Supply is below the write-inhibit level |
| sleep_req_i | input | 1 | Host request to enter sleep |
| wake_req_i | input | 1 | Host request to leave sleep |
| reset_req_i | input | 1 | Host request for a sleep-and-wake reset |
| bus_busy_i | input | 1 | A memory bus transaction is in progress |
| host_en_ni | input | NUM_EN | Host chip-enable strobes, active low |
| host_we_ni | input | 1 | Host write-enable strobe, active low |
| mem_en_no | output | NUM_EN | Chip-enable strobes to the memory, active low |
| mem_we_no | output | 1 | Write-enable strobe to the memory, active low |
| sleep_pin_o | output | 1 | Sleep/reset pin to the memory, active high |
| access_ok_o | output | 1 | Host may access the memory |
| asleep_o | output | 1 | Sleep entry is complete |

## Verification
The hardest cases to reach are the exit ordering and the brownout that arrives in the middle of a window. The exit ordering requires the strobe outputs to be high in the very cycle the sleep pin falls, even while the host drives them low. The bench holds host_en_ni and host_we_ni low during the wake. It samples the strobe outputs in the first cycle with the sleep pin low, then counts edges to the end of the initialisation wait. For the brownout case, the bench raises brownout_i partway through a startup window and checks the outputs combinationally. It then checks that the next power-good event restarts the full count rather than resuming the old one.

// File: rtl/mram_seq_pkg.sv
package mram_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STARTUP,
    ST_READY,
    ST_SLP_ENTER,
    ST_SLEEP,
    ST_WAKE
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
  parameter int unsigned NUM_EN = 4
) (
  input  logic              allow_i,
  input  logic [NUM_EN-1:0] en_ni,
  input  logic              we_ni,
  output logic [NUM_EN-1:0] en_no,
  output logic              we_no
);

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    assign en_no[g] = allow_i ? en_ni[g] : 1'b1;
  end

  assign we_no = allow_i ? we_ni : 1'b1;

endmodule

// File: rtl/mram_pwr_seq.sv
module mram_pwr_seq
  import mram_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned STARTUP_US = 2000,
  parameter int unsigned SLEEP_NS   = 40,
  parameter int unsigned WAKE_US    = 100,
  parameter int unsigned NUM_EN     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              brownout_i,
  input  logic              sleep_req_i,
  input  logic              wake_req_i,
  input  logic              reset_req_i,
  input  logic              bus_busy_i,
  input  logic [NUM_EN-1:0] host_en_ni,
  input  logic              host_we_ni,
  output logic [NUM_EN-1:0] mem_en_no,
  output logic              mem_we_no,
  output logic              sleep_pin_o,
  output logic              access_ok_o,
  output logic              asleep_o
);

  localparam int unsigned STARTUP_CYC = CLK_MHZ * STARTUP_US;
  localparam int unsigned SLEEP_CYC   = ns_to_cyc(SLEEP_NS, CLK_MHZ);
  localparam int unsigned WAKE_CYC    = CLK_MHZ * WAKE_US;
  localparam int unsigned MAX_A       = (STARTUP_CYC > WAKE_CYC) ? STARTUP_CYC : WAKE_CYC;
  localparam int unsigned MAX_CYC     = (MAX_A > SLEEP_CYC) ? MAX_A : SLEEP_CYC;
  localparam int unsigned CW          = $clog2(MAX_CYC + 1);

  seq_state_e    state_q, state_d;
  logic          rst_mode_q;
  logic          tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;
  logic          pwr_ok;

  assign pwr_ok = pwr_good_i && !brownout_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:       if (pwr_ok) state_d = ST_STARTUP;
      ST_STARTUP:   if (tmr_done) state_d = ST_READY;
      ST_READY:     if ((sleep_req_i || reset_req_i) && !bus_busy_i) state_d = ST_SLP_ENTER;
      ST_SLP_ENTER: if (tmr_done) state_d = rst_mode_q ? ST_WAKE : ST_SLEEP;
      ST_SLEEP:     if (wake_req_i) state_d = ST_WAKE;
      ST_WAKE:      if (tmr_done) state_d = ST_READY;
      default:      state_d = ST_OFF;
    endcase
    if (!pwr_ok) state_d = ST_OFF;
  end

  always_comb begin
    unique case (state_d)
      ST_STARTUP:   tmr_val = CW'(STARTUP_CYC - 1);
      ST_SLP_ENTER: tmr_val = CW'(SLEEP_CYC - 1);
      ST_WAKE:      tmr_val = CW'(WAKE_CYC - 1);
      default:      tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      rst_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_READY && state_d == ST_SLP_ENTER) rst_mode_q <= reset_req_i;
    end
  end

  seq_timer #(.CW(CW)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  assign access_ok_o = (state_q == ST_READY) && pwr_ok;
  assign sleep_pin_o = (state_q == ST_SLP_ENTER) || (state_q == ST_SLEEP);
  assign asleep_o    = (state_q == ST_SLEEP);

  strobe_gate #(.NUM_EN(NUM_EN)) i_gate (
    .allow_i (access_ok_o),
    .en_ni   (host_en_ni),
    .we_ni   (host_we_ni),
    .en_no   (mem_en_no),
    .we_no   (mem_we_no)
  );

  AST_BROWNOUT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brownout_i |-> (&mem_en_no && mem_we_no && !access_ok_o)); // R3

  AST_STARTUP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && $past(state_q) == ST_STARTUP) |-> $past(tmr_done)); // R2

  AST_SLEEP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> ($past(sleep_pin_o) && $past(tmr_done))); // R5

  AST_SLEEP_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_pin_o |-> (&mem_en_no && mem_we_no)); // R6

  AST_EXIT_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_pin_o) |-> (&mem_en_no && mem_we_no && !access_ok_o)); // R7

  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_pin_o) |-> ($past(access_ok_o) && !$past(bus_busy_i))); // R4

endmodule

// File: tb/test_mram_pwr_seq.sv
module test_mram_pwr_seq;

  localparam int unsigned NUM_EN  = 4;
  localparam int unsigned STARTUP = 200;
  localparam int unsigned SLP     = 4;
  localparam int unsigned WAKE    = 100;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_good = 1'b0, brownout = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, reset_req = 1'b0, bus_busy = 1'b0;
  logic [NUM_EN-1:0] host_en_n = '1;
  logic host_we_n = 1'b1;
  logic [NUM_EN-1:0] mem_en_n;
  logic mem_we_n, sleep_pin, access_ok, asleep;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  mram_pwr_seq #(.CLK_MHZ(100), .STARTUP_US(2), .SLEEP_NS(40), .WAKE_US(1), .NUM_EN(NUM_EN))
  i_mram_pwr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good), .brownout_i(brownout),
    .sleep_req_i(sleep_req), .wake_req_i(wake_req), .reset_req_i(reset_req),
    .bus_busy_i(bus_busy), .host_en_ni(host_en_n), .host_we_ni(host_we_n),
    .mem_en_no(mem_en_n), .mem_we_no(mem_we_n), .sleep_pin_o(sleep_pin),
    .access_ok_o(access_ok), .asleep_o(asleep)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [31:0] strobes();
    return {27'd0, mem_en_n, mem_we_n};
  endfunction

  task automatic do_startup(string req);
    host_en_n = 4'b1110;
    host_we_n = 1'b0;
    pwr_good  = 1'b1;
    tick(STARTUP / 2);
    chk(req, strobes(), 32'h1f);
    tick(STARTUP / 2);
    chk(req, access_ok, 0);
    tick(1);
    chk(req, access_ok, 1);
  endtask

  task automatic t_reset();
    host_en_n = '0;
    host_we_n = 1'b0;
    #1;
    chk("R1", {access_ok, sleep_pin, asleep}, 0);
    chk("R1", strobes(), 32'h1f);
    tick(2);
    rst_ni = 1'b1;
    tick(3);
    chk("R1", access_ok, 0);
  endtask

  task automatic t_startup();
    do_startup("R2");
  endtask

  task automatic t_pass();
    host_en_n = 4'b1011;
    host_we_n = 1'b0;
    #1;
    chk("R9", strobes(), {27'd0, 4'b1011, 1'b0});
    host_en_n = 4'b0111;
    host_we_n = 1'b1;
    #1;
    chk("R9", strobes(), {27'd0, 4'b0111, 1'b1});
  endtask

  task automatic t_ignored();
    wake_req = 1'b1;
    tick(3);
    chk("R10", {access_ok, sleep_pin}, 2'b10);
    wake_req = 1'b0;
  endtask

  task automatic t_busy_sleep_wake();
    bus_busy  = 1'b1;
    sleep_req = 1'b1;
    tick(3);
    chk("R4", {sleep_pin, access_ok}, 2'b01);
    bus_busy = 1'b0;
    tick(1);
    sleep_req = 1'b0;
    chk("R4", {sleep_pin, access_ok}, 2'b10);
    host_en_n = '0;
    host_we_n = 1'b0;
    #1;
    chk("R6", strobes(), 32'h1f);
    tick(SLP - 1);
    chk("R5", asleep, 0);
    tick(1);
    chk("R5", asleep, 1);
    wake_req = 1'b1;
    tick(1);
    wake_req = 1'b0;
    chk("R7", {sleep_pin, asleep, access_ok}, 0);
    chk("R7", strobes(), 32'h1f);
    tick(WAKE - 1);
    chk("R7", access_ok, 0);
    tick(1);
    chk("R7", access_ok, 1);
  endtask

  task automatic t_reset_req();
    reset_req = 1'b1;
    tick(1);
    reset_req = 1'b0;
    chk("R8", sleep_pin, 1);
    tick(SLP - 1);
    chk("R8", {sleep_pin, asleep}, 2'b10);
    tick(1);
    chk("R8", {sleep_pin, asleep, access_ok}, 0);
    tick(WAKE - 1);
    chk("R8", access_ok, 0);
    tick(1);
    chk("R8", access_ok, 1);
  endtask

  task automatic t_brownout();
    host_en_n = '0;
    brownout  = 1'b1;
    #1;
    chk("R3", {access_ok, strobes()[4:0]}, 6'h1f);
    tick(2);
    brownout = 1'b0;
    pwr_good = 1'b1;
    tick(STARTUP / 2);
    brownout = 1'b1;
    #1;
    chk("R3", access_ok, 0);
    tick(1);
    brownout = 1'b0;
    do_startup("R3");
    pwr_good = 1'b0;
    #1;
    chk("R3", access_ok, 0);
    tick(2);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_pass();
    t_ignored();
    t_busy_sleep_wake();
    t_reset_req();
    t_brownout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule